// File: doc/BRIEF.md
# Configurable Parallel Host Port

This block is the slave side of a parallel host port. An external host writes words into an input register and reads words from an output register. On the chip side, a consumer drains the input register with a single-cycle read pulse, and a producer fills the output register with a single-cycle write pulse. Two flags tell both sides the state of the buffers. Input-full is set when a host write completes. Output-empty is set when a host read completes.

A control register sets how the host side behaves. It chooses a full-width bus or a half-width bus. On the half-width bus it chooses one-lane or two-lane logical transfers, with a byte-select pin whose active level can be set. It chooses between a separate-read/write-strobe convention and a data-strobe plus read/write-line convention, and sets the level of the data strobe. It also sets the flag pin polarity, the option to merge both flags onto one pin, and the inversion of the output-empty status bit.

The host pins are asynchronous to the port clock. They pass through a synchronizer, and an access is taken as complete when the synchronized strobe is released.

Top module: `host_word_port`

## Requirements
- R1: After reset the control register is 0, stat_ibf is 0, stat_obe is 1, ibf_pin is 0, obe_pin is 1 and in_data is 0.
- R2: While hst_cs_n is high, any activity on hst_wrn_rw and hst_rdn_ds leaves both flags and in_data unchanged.
- R3: With control bit 7 set (full-width bus), a completed host write loads all DW bits of hst_din into in_data and sets stat_ibf. A host read returns the whole output register on hst_dout, and its completion sets the output-empty flag.
- R4: With bit 7 and bit 0 clear (half-width bus, one-lane transfers), a write loads the low lane of in_data and clears its high lane. A read returns the low lane of the output register with zeros above it. Every completed access sets its flag.
- R5: With bit 7 clear and bit 0 set (two-lane transfers), the high lane is addressed when hst_bsel differs from control bit 3, and the low lane otherwise. A write changes only the addressed lane of in_data, and a read returns the addressed lane in the low bits of hst_dout.
- R6: In two-lane mode, a flag is set only by an access to the high lane when bit 3 is 0, and only by an access to the low lane when bit 3 is 1. Otherwise the flags hold their value.
- R7: With control bit 1 clear, hst_wrn_rw is an active-low write strobe and hst_rdn_ds is an active-low read strobe.
- R8: With control bit 1 set, hst_rdn_ds is a data strobe that is active when it equals control bit 2. hst_wrn_rw high during the strobe means a read, and low means a write.
- R9: A pulse on in_rd clears stat_ibf. A pulse on out_wr loads out_data into the output register and clears the output-empty flag. A host completion in the same cycle takes priority over the clear.
- R10: Control bit 4 inverts obe_pin, and it inverts ibf_pin when bit 5 is clear.
- R11: With control bit 5 set, ibf_pin carries the OR of the input-full and output-empty flags, active high, whatever the value of bit 4.
- R12: Control bit 6 inverts stat_obe only. obe_pin does not depend on it.
- R13: A flag set by a host access changes on the third rising clock edge after the strobe is released, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Load the control register |
| ctrl_wdata | input | 8 | New control value |
| in_rd | input | 1 | Internal read of the input register; clears input-full |
| in_data | output | DW | Input register contents |
| out_wr | input | 1 | Internal load of the output register; clears output-empty |
| out_data | input | DW | Value loaded on out_wr |
| hst_cs_n | input | 1 | Host chip select, active low |
| hst_wrn_rw | input | 1 | Write strobe (low active) or read/write line |
| hst_rdn_ds | input | 1 | Read strobe (low active) or data strobe |
| hst_bsel | input | 1 | Host lane select for two-lane mode |
| hst_din | input | DW | Host write data |
| hst_dout | output | DW | Host read data |
| ibf_pin | output | 1 | Input-full pin, or the merged flag |
| obe_pin | output | 1 | Output-empty pin |
| stat_ibf | output | 1 | Input-full status bit |
| stat_obe | output | 1 | Output-empty status bit, polarity per bit 6 |

## Verification
The bound checker watches the flag registers on every cycle:
- A flag may only rise one cycle after a qualifying host completion.
- A flag may only fall one cycle after the internal read or write pulse.
- A flag holds its value at all other times.
- The pin and status polarity relations of R10 to R12 hold continuously.

Only the directed scenarios can show the following:
- Lane assembly and lane splitting.
- Which lane fires the flag under each byte-select polarity.
- Decoding of both strobe conventions and of both data-strobe levels.
- That chip-select-high activity is ignored.
- The exact three-edge latency from strobe release to flag.

// File: rtl/hwp_pkg.sv
package hwp_pkg;

   localparam int CTRL_W = 8;

   // Field order follows control bit positions 7 down to 0.
   typedef struct packed {
      logic bus_full;      // bit 7: full-width external bus
      logic stat_obe_inv;  // bit 6: invert output-empty status bit
      logic flag_merge;    // bit 5: OR of both flags onto ibf pin
      logic pin_inv;       // bit 4: invert flag pins
      logic bsel_lvl;      // bit 3: byte-select level / trigger lane
      logic ds_lvl;        // bit 2: active level of data strobe
      logic ds_style;      // bit 1: data strobe + read/write line
      logic two_lane;      // bit 0: two-lane logical transfers
   } hwp_ctrl_t;

   localparam hwp_ctrl_t CTRL_RESET = '0;

endpackage

// File: rtl/hwp_sync.sv
module hwp_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hwp_sync: STAGES must be at least 2");
      end
   endgenerate

   // Reset value of all ones matches idle host pins (strobes and select inactive).
   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stg
         logic [W-1:0] r;
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= '1;
               else        r <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= '1;
               else        r <= g_stg[i-1].r;
            end
         end
      end
   endgenerate

   assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/hwp_strobe_dec.sv
module hwp_strobe_dec (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_s,
   input  logic a_s,
   input  logic b_s,
   input  logic ds_style,
   input  logic ds_lvl,
   output logic wr_act,
   output logic rd_act,
   output logic wr_done,
   output logic rd_done
);

   logic sel;
   logic ds_on;
   logic wr_q;
   logic rd_q;

   always_comb begin
      sel   = ~cs_n_s;
      ds_on = (b_s == ds_lvl);
      if (ds_style) begin
         // a_s is the read/write line, b_s the data strobe
         wr_act = sel & ds_on & ~a_s;
         rd_act = sel & ds_on &  a_s;
      end else begin
         // a_s is the write strobe, b_s the read strobe, both low active
         wr_act = sel & ~a_s;
         rd_act = sel & ~b_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= 1'b0;
         rd_q <= 1'b0;
      end else begin
         wr_q <= wr_act;
         rd_q <= rd_act;
      end
   end

   assign wr_done = wr_q & ~wr_act;
   assign rd_done = rd_q & ~rd_act;

endmodule

// File: rtl/hwp_lane.sv
module hwp_lane #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_full,
   input  logic          two_lane,
   input  logic          bsel_lvl,
   input  logic          wr_act,
   input  logic          rd_act,
   input  logic          wr_done,
   input  logic          out_wr,
   input  logic [DW-1:0] out_data,
   input  logic [DW-1:0] hst_din,
   input  logic          hst_bsel,
   output logic [DW-1:0] in_word,
   output logic [DW-1:0] hst_dout,
   output logic          lane_trig
);

   localparam int LW = DW / 2;
   localparam int HW = DW - LW;

   logic [DW-1:0] cap_d;
   logic          cap_b;
   logic          cap_hi;
   logic          raw_hi;
   logic [DW-1:0] out_word;
   logic [LW-1:0] out_lane;

   // Host data and lane select are held while the synchronized strobe is active.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_d <= '0;
         cap_b <= 1'b0;
      end else if (wr_act | rd_act) begin
         cap_d <= hst_din;
         cap_b <= hst_bsel;
      end
   end

   assign cap_hi = cap_b ^ bsel_lvl;
   assign raw_hi = hst_bsel ^ bsel_lvl;

   // Flag-bearing lane: high lane when bsel_lvl is 0, low lane when it is 1.
   assign lane_trig = bus_full | ~two_lane | (cap_hi ^ bsel_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_word <= '0;
      end else if (wr_done) begin
         if (bus_full) begin
            in_word <= cap_d;
         end else if (!two_lane) begin
            in_word <= {{HW{1'b0}}, cap_d[LW-1:0]};
         end else if (cap_hi) begin
            in_word[DW-1:LW] <= cap_d[HW-1:0];
         end else begin
            in_word[LW-1:0] <= cap_d[LW-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      out_word <= '0;
      else if (out_wr) out_word <= out_data;
   end

   always_comb begin
      out_lane = out_word[LW-1:0];
      if (two_lane && raw_hi) out_lane = out_word[DW-1:DW-LW];
      if (bus_full) hst_dout = out_word;
      else          hst_dout = {{HW{1'b0}}, out_lane};
   end

endmodule

// File: rtl/hwp_flags.sv
module hwp_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ibf,
   input  logic clr_ibf,
   input  logic set_obe,
   input  logic clr_obe,
   input  logic pin_inv,
   input  logic flag_merge,
   input  logic stat_obe_inv,
   output logic ibf_q,
   output logic obe_q,
   output logic ibf_pin,
   output logic obe_pin,
   output logic stat_ibf,
   output logic stat_obe
);

   // A host completion wins over a same-cycle internal clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ibf_q <= 1'b0;
         obe_q <= 1'b1;
      end else begin
         if (set_ibf)      ibf_q <= 1'b1;
         else if (clr_ibf) ibf_q <= 1'b0;
         if (set_obe)      obe_q <= 1'b1;
         else if (clr_obe) obe_q <= 1'b0;
      end
   end

   always_comb begin
      obe_pin  = obe_q ^ pin_inv;
      ibf_pin  = flag_merge ? (ibf_q | obe_q) : (ibf_q ^ pin_inv);
      stat_ibf = ibf_q;
      stat_obe = obe_q ^ stat_obe_inv;
   end

endmodule

// File: rtl/host_word_port.sv
module host_word_port
   import hwp_pkg::*;
#(
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              in_rd,
   output logic [DW-1:0]     in_data,
   input  logic              out_wr,
   input  logic [DW-1:0]     out_data,
   input  logic              hst_cs_n,
   input  logic              hst_wrn_rw,
   input  logic              hst_rdn_ds,
   input  logic              hst_bsel,
   input  logic [DW-1:0]     hst_din,
   output logic [DW-1:0]     hst_dout,
   output logic              ibf_pin,
   output logic              obe_pin,
   output logic              stat_ibf,
   output logic              stat_obe
);

   generate
      if (DW < 4 || (DW % 2) != 0) begin : g_bad_dw
         $error("host_word_port: DW must be even and at least 4");
      end
   endgenerate

   hwp_ctrl_t ctrl_q;
   logic      cs_n_s, a_s, b_s;
   logic      wr_act, rd_act, wr_done, rd_done;
   logic      lane_trig;
   logic      ibf_q, obe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= CTRL_RESET;
      else if (ctrl_we) ctrl_q <= hwp_ctrl_t'(ctrl_wdata);
   end

   hwp_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({hst_cs_n, hst_wrn_rw, hst_rdn_ds}),
      .q     ({cs_n_s, a_s, b_s})
   );

   hwp_strobe_dec u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n_s   (cs_n_s),
      .a_s      (a_s),
      .b_s      (b_s),
      .ds_style (ctrl_q.ds_style),
      .ds_lvl   (ctrl_q.ds_lvl),
      .wr_act   (wr_act),
      .rd_act   (rd_act),
      .wr_done  (wr_done),
      .rd_done  (rd_done)
   );

   hwp_lane #(.DW(DW)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_full  (ctrl_q.bus_full),
      .two_lane  (ctrl_q.two_lane),
      .bsel_lvl  (ctrl_q.bsel_lvl),
      .wr_act    (wr_act),
      .rd_act    (rd_act),
      .wr_done   (wr_done),
      .out_wr    (out_wr),
      .out_data  (out_data),
      .hst_din   (hst_din),
      .hst_bsel  (hst_bsel),
      .in_word   (in_data),
      .hst_dout  (hst_dout),
      .lane_trig (lane_trig)
   );

   hwp_flags u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_ibf      (wr_done & lane_trig),
      .clr_ibf      (in_rd),
      .set_obe      (rd_done & lane_trig),
      .clr_obe      (out_wr),
      .pin_inv      (ctrl_q.pin_inv),
      .flag_merge   (ctrl_q.flag_merge),
      .stat_obe_inv (ctrl_q.stat_obe_inv),
      .ibf_q        (ibf_q),
      .obe_q        (obe_q),
      .ibf_pin      (ibf_pin),
      .obe_pin      (obe_pin),
      .stat_ibf     (stat_ibf),
      .stat_obe     (stat_obe)
   );

endmodule

// File: rtl/hwp_chk.sv
module hwp_chk (
   input logic clk,
   input logic rst_n,
   input logic pin_inv,
   input logic flag_merge,
   input logic sobe_inv,
   input logic wr_fin,
   input logic rd_fin,
   input logic hit,
   input logic in_rd,
   input logic out_wr,
   input logic ibf,
   input logic obe,
   input logic ibf_pin,
   input logic obe_pin,
   input logic stat_ibf,
   input logic stat_obe
);

   a_r3_ibf_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fin && hit) |=> ibf);

   a_r3_obe_set: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fin && hit) |=> obe);

   a_r9_ibf_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (in_rd && !(wr_fin && hit)) |=> !ibf);

   a_r9_obe_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (out_wr && !(rd_fin && hit)) |=> !obe);

   a_r6_ibf_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_fin && hit) && !in_rd) |=> $stable(ibf));

   a_r6_obe_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(rd_fin && hit) && !out_wr) |=> $stable(obe));

   a_r10_ibf_pin: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_merge |-> (ibf_pin == (stat_ibf ^ pin_inv)));

   a_r11_merge: assert property (@(posedge clk) disable iff (!rst_n)
      flag_merge |-> (ibf_pin == (stat_ibf | (stat_obe ^ sobe_inv))));

   a_r12_pin_vs_status: assert property (@(posedge clk) disable iff (!rst_n)
      obe_pin == (stat_obe ^ sobe_inv ^ pin_inv));

   a_r1_obe_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> obe);

endmodule

bind host_word_port hwp_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pin_inv    (ctrl_q.pin_inv),
   .flag_merge (ctrl_q.flag_merge),
   .sobe_inv   (ctrl_q.stat_obe_inv),
   .wr_fin     (wr_done),
   .rd_fin     (rd_done),
   .hit        (lane_trig),
   .in_rd      (in_rd),
   .out_wr     (out_wr),
   .ibf        (ibf_q),
   .obe        (obe_q),
   .ibf_pin    (ibf_pin),
   .obe_pin    (obe_pin),
   .stat_ibf   (stat_ibf),
   .stat_obe   (stat_obe)
);

// File: tb/host_word_port_bench.sv
module host_word_port_bench;

   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctrl_we = 1'b0;
   logic [7:0]    ctrl_wdata = '0;
   logic          in_rd = 1'b0;
   logic [DW-1:0] in_data;
   logic          out_wr = 1'b0;
   logic [DW-1:0] out_data = '0;
   logic          hst_cs_n = 1'b1;
   logic          hst_wrn_rw = 1'b1;
   logic          hst_rdn_ds = 1'b1;
   logic          hst_bsel = 1'b0;
   logic [DW-1:0] hst_din = '0;
   logic [DW-1:0] hst_dout;
   logic          ibf_pin, obe_pin, stat_ibf, stat_obe;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  ds_mode = 1'b0;
   bit  ds_hi   = 1'b0;

   always #5 clk = ~clk;

   host_word_port #(.DW(DW), .SYNC_STAGES(2)) u_host_word_port (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .in_rd(in_rd), .in_data(in_data), .out_wr(out_wr), .out_data(out_data),
      .hst_cs_n(hst_cs_n), .hst_wrn_rw(hst_wrn_rw), .hst_rdn_ds(hst_rdn_ds),
      .hst_bsel(hst_bsel), .hst_din(hst_din), .hst_dout(hst_dout),
      .ibf_pin(ibf_pin), .obe_pin(obe_pin), .stat_ibf(stat_ibf), .stat_obe(stat_obe)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic cfg(input logic [7:0] v);
      @(negedge clk);
      ctrl_wdata = v;
      ctrl_we    = 1'b1;
      @(negedge clk);
      ctrl_we    = 1'b0;
      ds_mode    = v[1];
      ds_hi      = v[2];
      hst_wrn_rw = 1'b1;
      hst_rdn_ds = ds_mode ? ~ds_hi : 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic host_xfer(input bit wr, input logic [15:0] d, input logic bs,
                            input bit tmg, output logic [15:0] rd);
      @(negedge clk);
      hst_din  = d;
      hst_bsel = bs;
      if (ds_mode) hst_wrn_rw = wr ? 1'b0 : 1'b1;
      hst_cs_n = 1'b0;
      @(negedge clk);
      if (ds_mode)  hst_rdn_ds = ds_hi;
      else if (wr)  hst_wrn_rw = 1'b0;
      else          hst_rdn_ds = 1'b0;
      repeat (4) @(negedge clk);
      rd = hst_dout;
      if (ds_mode) hst_rdn_ds = ~ds_hi;
      else begin
         hst_wrn_rw = 1'b1;
         hst_rdn_ds = 1'b1;
      end
      @(negedge clk);
      @(negedge clk);
      if (tmg) chk("R13", "flag before third edge", wr ? stat_ibf : stat_obe, 0);
      @(negedge clk);
      if (tmg) chk("R13", "flag at third edge", wr ? stat_ibf : stat_obe, 1);
      hst_cs_n   = 1'b1;
      hst_wrn_rw = 1'b1;
      @(negedge clk);
   endtask

   task automatic int_read();
      @(negedge clk); in_rd = 1'b1;
      @(negedge clk); in_rd = 1'b0;
   endtask

   task automatic int_write(input logic [15:0] v);
      @(negedge clk); out_data = v; out_wr = 1'b1;
      @(negedge clk); out_wr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "stat_ibf", stat_ibf, 0);
      chk("R1", "stat_obe", stat_obe, 1);
      chk("R1", "ibf_pin", ibf_pin, 0);
      chk("R1", "obe_pin", obe_pin, 1);
      chk("R1", "in_data", in_data, 0);
   endtask

   task automatic t_full_bus();
      logic [15:0] r;
      cfg(8'h80);
      host_xfer(1'b1, 16'hA55A, 1'b0, 1'b1, r);
      chk("R3", "in_data full word", in_data, 16'hA55A);
      chk("R7", "write strobe sets ibf", stat_ibf, 1);
      int_read();
      chk("R9", "in_rd clears ibf", stat_ibf, 0);
      int_write(16'h1234);
      chk("R9", "out_wr clears obe", stat_obe, 0);
      host_xfer(1'b0, 16'h0000, 1'b0, 1'b1, r);
      chk("R3", "read full word", r, 16'h1234);
      chk("R7", "read strobe leaves ibf", stat_ibf, 0);
   endtask

   task automatic t_one_lane();
      logic [15:0] r;
      cfg(8'h00);
      host_xfer(1'b1, 16'h77C3, 1'b0, 1'b0, r);
      chk("R4", "low lane write, high cleared", in_data, 16'h00C3);
      chk("R4", "ibf set", stat_ibf, 1);
      int_read();
      int_write(16'hBEEF);
      host_xfer(1'b0, 16'h0000, 1'b1, 1'b0, r);
      chk("R4", "read low lane only", r, 16'h00EF);
      chk("R4", "obe set", stat_obe, 1);
   endtask

   task automatic t_two_lane();
      logic [15:0] r;
      cfg(8'h01);
      host_xfer(1'b1, 16'h00CD, 1'b0, 1'b0, r);
      chk("R6", "low lane no flag (bit3=0)", stat_ibf, 0);
      host_xfer(1'b1, 16'h00AB, 1'b1, 1'b0, r);
      chk("R6", "high lane flags (bit3=0)", stat_ibf, 1);
      chk("R5", "assembled word (bit3=0)", in_data, 16'hABCD);
      int_read();
      cfg(8'h09);
      host_xfer(1'b1, 16'h0012, 1'b0, 1'b0, r);
      chk("R6", "high lane no flag (bit3=1)", stat_ibf, 0);
      host_xfer(1'b1, 16'h0034, 1'b1, 1'b0, r);
      chk("R6", "low lane flags (bit3=1)", stat_ibf, 1);
      chk("R5", "assembled word (bit3=1)", in_data, 16'h1234);
      int_read();
      int_write(16'h5678);
      host_xfer(1'b0, 16'h0000, 1'b0, 1'b0, r);
      chk("R5", "read high lane", r, 16'h0056);
      chk("R6", "high read no flag", stat_obe, 0);
      host_xfer(1'b0, 16'h0000, 1'b1, 1'b0, r);
      chk("R5", "read low lane", r, 16'h0078);
      chk("R6", "low read flags", stat_obe, 1);
   endtask

   task automatic t_data_strobe();
      logic [15:0] r;
      cfg(8'h82);
      host_xfer(1'b1, 16'h0F0F, 1'b0, 1'b0, r);
      chk("R8", "low-level strobe write", in_data, 16'h0F0F);
      chk("R8", "ibf set", stat_ibf, 1);
      int_read();
      cfg(8'h86);
      host_xfer(1'b1, 16'hF00F, 1'b0, 1'b1, r);
      chk("R8", "high-level strobe write", in_data, 16'hF00F);
      int_read();
      int_write(16'h4321);
      host_xfer(1'b0, 16'h0000, 1'b0, 1'b0, r);
      chk("R8", "high-level strobe read", r, 16'h4321);
      chk("R8", "obe set by read", stat_obe, 1);
   endtask

   task automatic t_select_gate();
      cfg(8'h80);
      int_write(16'h9999);
      @(negedge clk); hst_din = 16'hDEAD; hst_wrn_rw = 1'b0;
      repeat (4) @(negedge clk); hst_wrn_rw = 1'b1;
      repeat (5) @(negedge clk);
      chk("R2", "ibf unchanged", stat_ibf, 0);
      chk("R2", "in_data unchanged", in_data, 16'hF00F);
      hst_rdn_ds = 1'b0;
      repeat (4) @(negedge clk); hst_rdn_ds = 1'b1;
      repeat (5) @(negedge clk);
      chk("R2", "obe unchanged", stat_obe, 0);
   endtask

   task automatic t_pins();
      logic [15:0] r;
      cfg(8'h10);
      chk("R10", "ibf_pin inverted", ibf_pin, 1);
      chk("R10", "obe_pin inverted", obe_pin, 1);
      cfg(8'h20);
      chk("R11", "merged pin low", ibf_pin, 0);
      host_xfer(1'b0, 16'h0000, 1'b0, 1'b0, r);
      chk("R11", "merged pin follows obe", ibf_pin, 1);
      cfg(8'h30);
      chk("R11", "merged pin ignores bit4", ibf_pin, 1);
      chk("R10", "obe_pin inverted with merge", obe_pin, 0);
      cfg(8'h40);
      chk("R12", "status inverted", stat_obe, 0);
      chk("R12", "pin not inverted", obe_pin, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_bus();
      t_one_lane();
      t_two_lane();
      t_data_strobe();
      t_select_gate();
      t_pins();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule